// File: doc/BRIEF.md
# Bus Hold Arbiter

This block lets an outside device take over the external memory bus. The device pulls an active-low hold request. The bus interface reports whether it is idle. The arbiter then answers with an active-low acknowledge and drives a float enable for the address, data, read, write and byte-high-enable pads. It also raises a stall towards the local bus master, so that no new bus cycle starts while the bus is lent out.

All state changes happen on a falling edge of the bus clock. The bus clock arrives as a level that is synchronous to the system clock `clk`, and the falling edge is found internally. A hold is granted only when the bus is idle. The pads float one bus-clock period after the acknowledge falls. On release, the acknowledge rises first and the pads are driven again one bus-clock period later. The stall ends in that same cycle, so a bus request that waited during the hold can only start once the pads are driven. The hold request is asynchronous and passes through a synchronizer before it is evaluated.

Top module: `hold_arbiter`

## Requirements
- R1: While `rst_n` is low, and after reset, `hlda_n_o` is 1, `pin_float_o` is 0 and `master_stall_o` is 0. An active reset forces `pin_float_o` to 0 at once, even in the middle of a hold.
- R2: A bus-phase fall is a clock edge at which `bus_phase_i` is 0 and was 1 at the previous edge. In the idle state, a fall seen with the synchronized hold low and `bus_idle_i` high drives `hlda_n_o` to 0 and `master_stall_o` to 1 after that edge.
- R3: A fall that sees `bus_idle_i` low does not grant the hold, and `hlda_n_o` stays 1.
- R4: Without a bus-phase fall, none of the three outputs changes.
- R5: `pin_float_o` rises at the first bus-phase fall after `hlda_n_o` fell, and never while `hlda_n_o` is 1.
- R6: While the pads float, `hlda_n_o` returns to 1 at the first fall that sees the synchronized hold high. Until then the pads stay floating, whatever `bus_idle_i` does.
- R7: `pin_float_o` returns to 0 at the first fall after `hlda_n_o` rose, and `master_stall_o` falls in that same cycle. The stall is never 0 while the pads float.
- R8: If the hold is withdrawn before the pads float, the full sequence still runs: float first, then acknowledge high, then drive.
- R9: A hold request that is present during the release period is not granted before the arbiter is idle again. It is granted at the fall after that.
- R10: `hold_n_i` passes through SYNC_STAGES flip-flops (default 2). A change becomes visible only to a fall that occurs at least SYNC_STAGES clock edges after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_phase_i | input | 1 | Bus clock level, synchronous to clk |
| hold_n_i | input | 1 | Active-low hold request from the outside device (asynchronous) |
| bus_idle_i | input | 1 | High when no bus cycle is in progress |
| hlda_n_o | output | 1 | Active-low hold acknowledge |
| pin_float_o | output | 1 | High puts address, data, read, write and byte-high pads in high impedance |
| master_stall_o | output | 1 | High holds off the local bus master |

## Verification
The checker assumes that `bus_phase_i` changes only between clock edges and stays at each level for at least one clock. Under that assumption every fall is a single-cycle event, and output changes can be tied to the previous two samples of the bus phase. It also assumes that `bus_idle_i` is valid at each fall. The bench drives every input on the falling edge of `clk` and keeps the bus phase high for at least one clock before each low phase. Hold changes are placed either well ahead of a fall or deliberately one clock short of the synchronizer depth.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,  // bus owned locally
    ST_GRANT = 2'd1,  // acknowledge low, pads still driven
    ST_FLOAT = 2'd2,  // acknowledge low, pads floating
    ST_GIVE  = 2'd3   // acknowledge high, pads still floating
  } hold_state_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '1;
        else        chain_q <= async_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/phase_fall_det.sv
module phase_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= phase_i;

  assign fall_o = prev_q & ~phase_i;
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic hold_n_sync_i,
  input  logic idle_i,
  output logic hlda_n_o,
  output logic float_o,
  output logic stall_o
);
  hold_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (fall_i) begin
      unique case (state_q)
        ST_RUN:   if (!hold_n_sync_i && idle_i) state_d = ST_GRANT;
        ST_GRANT: state_d = ST_FLOAT;
        ST_FLOAT: if (hold_n_sync_i) state_d = ST_GIVE;
        ST_GIVE:  state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;

  assign hlda_n_o = !((state_q == ST_GRANT) || (state_q == ST_FLOAT));
  assign float_o  = (state_q == ST_FLOAT) || (state_q == ST_GIVE);
  assign stall_o  = (state_q != ST_RUN);
endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_phase_i,
  input  logic hold_n_i,
  input  logic bus_idle_i,
  output logic hlda_n_o,
  output logic pin_float_o,
  output logic master_stall_o
);
  logic hold_n_s;
  logic phase_fall;

  hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(hold_n_i), .sync_o(hold_n_s)
  );

  phase_fall_det u_fall (
    .clk(clk), .rst_n(rst_n), .phase_i(bus_phase_i), .fall_o(phase_fall)
  );

  hold_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fall_i(phase_fall), .hold_n_sync_i(hold_n_s),
    .idle_i(bus_idle_i), .hlda_n_o(hlda_n_o), .float_o(pin_float_o),
    .stall_o(master_stall_o)
  );
endmodule

// File: rtl/hold_arbiter_chk.sv
module hold_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_phase_i,
  input logic bus_idle_i,
  input logic hlda_n_o,
  input logic pin_float_o,
  input logic master_stall_o
);
  // R1: pads never float while reset is held
  always @(posedge clk)
    if (!rst_n) p_reset_drive_r1: assert (!pin_float_o && hlda_n_o && !master_stall_o);

  p_grant_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda_n_o) |-> $past(bus_idle_i) && master_stall_o);

  p_edge_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hlda_n_o) || !$stable(pin_float_o)) |-> ($past(bus_phase_i, 2) && !$past(bus_phase_i)));

  p_float_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_float_o) |-> (!hlda_n_o && $past(!hlda_n_o)));

  p_release_floating_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda_n_o) |-> pin_float_o);

  p_stall_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_float_o |-> master_stall_o);

  p_drive_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_float_o) |-> (hlda_n_o && $past(hlda_n_o) && !master_stall_o));
endmodule

bind hold_arbiter hold_arbiter_chk u_chk (.*);

// File: tb/test_hold_arbiter.sv
module test_hold_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_phase_i = 1'b1;
  logic hold_n_i = 1'b1;
  logic bus_idle_i = 1'b1;
  logic hlda_n_o, pin_float_o, master_stall_o;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  hold_arbiter i_hold_arbiter (.*);

  // vector: {hold_n, idle, exp hlda_n, exp float, exp stall}
  localparam int NV = 19;
  localparam logic [4:0] VEC [0:NV-1] = '{
    5'b11_100,  // 0  R2 no request
    5'b00_100,  // 1  R3 busy blocks grant
    5'b01_001,  // 2  R2 grant
    5'b01_011,  // 3  R5 float
    5'b00_011,  // 4  R6 stays floating, idle ignored
    5'b11_111,  // 5  R6 acknowledge high
    5'b11_100,  // 6  R7 driven, stall off
    5'b01_001,  // 7  R2 grant
    5'b11_011,  // 8  R8 withdrawn early, still floats
    5'b11_111,  // 9  R8 release
    5'b11_100,  // 10 R8 back to run
    5'b01_001,  // 11 R2
    5'b01_011,  // 12 R5
    5'b11_111,  // 13 R6
    5'b01_100,  // 14 R9 request during release waits
    5'b01_001,  // 15 R9 granted afterwards
    5'b01_011,  // 16 R5
    5'b11_111,  // 17 R6
    5'b11_100   // 18 R7
  };
  localparam int REQ [0:NV-1] = '{2,3,2,5,6,6,7,2,8,8,8,2,5,6,9,9,5,6,7};

  task automatic check(input int req, input logic [2:0] exp);
    logic [2:0] act;
    act = {hlda_n_o, pin_float_o, master_stall_o};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: {hlda_n,float,stall} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic quiet(input int n);
    bus_phase_i = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic fall_tick();
    bus_phase_i = 1'b1;
    @(negedge clk);
    bus_phase_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 3'b100);  // R1 during reset
    rst_n = 1'b1;
    quiet(3);
    check(1, 3'b100);  // R1 after reset

    // R10: request one clock short of the synchronizer depth is not seen
    hold_n_i = 1'b0;
    fall_tick();
    check(10, 3'b100);
    // R4: no fall, no change
    quiet(6);
    check(4, 3'b100);
    fall_tick();
    check(10, 3'b001);  // now granted (R10/R2)
    hold_n_i = 1'b1;
    quiet(3);
    check(4, 3'b001);   // R4: hold withdrawn, no fall yet
    fall_tick(); fall_tick(); fall_tick();
    check(7, 3'b100);

    // main vector table
    for (int i = 0; i < NV; i++) begin
      hold_n_i   = VEC[i][4];
      bus_idle_i = VEC[i][3];
      quiet(3);
      fall_tick();
      check(REQ[i], VEC[i][2:0]);
    end

    // R1: reset in the middle of a hold
    hold_n_i = 1'b0; bus_idle_i = 1'b1;
    quiet(3);
    fall_tick(); fall_tick();
    check(5, 3'b011);
    rst_n = 1'b0;
    #1;
    check(1, 3'b100);
    hold_n_i = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    quiet(3);
    fall_tick();
    check(1, 3'b100);

    finish_run();
  end
endmodule